// File: doc/BRIEF.md
# Dual-Key Watchdog Timer

This block is a watchdog counter that asks for a chip reset when software stops servicing it. Servicing is deliberately hard to do by accident: the count only restarts after two different key words land in two different write-only registers. The two writes may come in either order, and any wrong word throws away whatever key progress had been made.

A free-running counter advances on every clock after reset. When it reaches its terminal count without a completed key pair, the block pulses a reset request for one cycle. It also restarts its own count, drops any half-entered key, and sets a sticky cause flag. The flag stays set through any number of later services and timeouts. Only the external active-low reset pin clears it, so software can tell after a restart why the chip went down. The pin reset is applied at once and released in step with the clock through a short synchronizer.

Top module: `wdog_dualkey`

## Requirements
- R1: While the pin reset is low and after it is released, the reset request is low and the status word reads 0. The count starts from zero once the internal reset is released, two clock edges after the pin rises.
- R2: A write of exactly 0xA (all other data bits zero) to offset 0x10, followed by a write of exactly 0x5 to offset 0x14, restarts the count to zero on the clock edge of the second write.
- R3: The same two writes in the opposite order (0x5 to offset 0x14 first, then 0xA to offset 0x10) also restart the count on the edge of the second write.
- R4: A write of any other word to either key offset discards both entered keys. A correct key written afterwards on its own does not restart the count.
- R5: With no completed key pair, the reset request rises exactly TIMEOUT clock edges after the last restart and stays high for exactly one cycle. The count then restarts by itself.
- R6: A timeout sets the status flag, bit 0 of the word read at offset 0x18, on the same edge that raises the reset request. A write to offset 0x18 has no effect on the flag.
- R7: Once set, the status flag survives further key pairs and further timeouts. It returns to 0 only through the pin reset.
- R8: A read returns zero at every offset other than 0x18, and bits above bit 0 of the status word always read zero.
- R9: A timeout also discards a half-entered key pair. The matching second key written after the timeout does not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| pin_rst_ni | input | 1 | External active-low reset pin; asserts asynchronously, releases through a synchronizer |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data; a key must match the whole word |
| bus_rdata_o | output | DATA_W | Read data, combinational from strobe and offset |
| rst_req_o | output | 1 | One-cycle chip-reset request on timeout |

## Verification
Each key write takes effect on the edge it is presented to. A restart is therefore fixed to that edge, and the reset request is due in the cycle after edge restart+TIMEOUT, with the status flag set on that same edge. Read data is combinational, so status is sampled a moment after the strobe is applied, between edges. Every scenario task tracks how many edges have passed since the last restart, including the edges spent on key writes. It checks the request low at each falling edge before the due cycle, high in the due cycle and low again in the next one, so a restart that happens early, late or not at all shifts the pulse and is caught.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  // Fixed register offsets; software depends on them.
  localparam int unsigned OFF_KEY_FIRST  = 32'h10;
  localparam int unsigned OFF_KEY_SECOND = 32'h14;
  localparam int unsigned OFF_CAUSE      = 32'h18;

  // Key words that must be written to the two clear registers.
  localparam int unsigned KEY_FIRST_VAL  = 32'hA;
  localparam int unsigned KEY_SECOND_VAL = 32'h5;

  // Decoded write request handed from the bus decoder to the key tracker.
  typedef struct packed {
    logic wr_first;   // write to first key offset
    logic wr_second;  // write to second key offset
    logic key_ok;     // written word equals the key of the addressed register
  } key_wr_t;
endpackage

// File: rtl/wdk_rst_sync.sv
module wdk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic pin_rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge pin_rst_ni) begin
    if (!pin_rst_ni) sync_q <= '0;
    else             sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdk_bus_dec.sv
module wdk_bus_dec
  import wdk_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              cause_flag_i,
  output key_wr_t           key_wr_o,
  output logic [DATA_W-1:0] bus_rdata_o
);
  localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(OFF_KEY_FIRST);
  localparam logic [ADDR_W-1:0] A_SECOND = ADDR_W'(OFF_KEY_SECOND);
  localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(OFF_CAUSE);
  localparam logic [DATA_W-1:0] K_FIRST  = DATA_W'(KEY_FIRST_VAL);
  localparam logic [DATA_W-1:0] K_SECOND = DATA_W'(KEY_SECOND_VAL);

  logic hit_first, hit_second, hit_cause;

  always_comb begin
    hit_first  = (bus_addr_i == A_FIRST);
    hit_second = (bus_addr_i == A_SECOND);
    hit_cause  = (bus_addr_i == A_CAUSE);

    key_wr_o.wr_first  = bus_wr_i && hit_first;
    key_wr_o.wr_second = bus_wr_i && hit_second;
    key_wr_o.key_ok    = (hit_first  && (bus_wdata_i == K_FIRST)) ||
                         (hit_second && (bus_wdata_i == K_SECOND));

    bus_rdata_o = '0;
    if (bus_rd_i && hit_cause) bus_rdata_o[0] = cause_flag_i;
  end

  // R8: only the cause offset can return a non-zero word
  always_comb begin
    if (!(bus_rd_i && hit_cause))
      a_rd_zero_r8: assert (bus_rdata_o == '0);
  end
endmodule

// File: rtl/wdk_key_arm.sv
module wdk_key_arm
  import wdk_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  key_wr_t key_wr_i,
  input  logic    expire_i,
  output logic    kick_o
);
  logic arm_first_q, arm_second_q;
  logic arm_first_d, arm_second_d;
  logic bad_write;

  // next-state
  always_comb begin
    kick_o = key_wr_i.key_ok &&
             ((key_wr_i.wr_first  && arm_second_q) ||
              (key_wr_i.wr_second && arm_first_q));
    bad_write = (key_wr_i.wr_first || key_wr_i.wr_second) && !key_wr_i.key_ok;

    arm_first_d  = arm_first_q;
    arm_second_d = arm_second_q;
    if (expire_i || kick_o || bad_write) begin
      arm_first_d  = 1'b0;
      arm_second_d = 1'b0;
    end else if (key_wr_i.wr_first) begin
      arm_first_d  = 1'b1;
    end else if (key_wr_i.wr_second) begin
      arm_second_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_first_q  <= 1'b0;
      arm_second_q <= 1'b0;
    end else begin
      arm_first_q  <= arm_first_d;
      arm_second_q <= arm_second_d;
    end
  end

  // R4: a wrong word drops every key entered so far
  p_bad_key_drops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((key_wr_i.wr_first || key_wr_i.wr_second) && !key_wr_i.key_ok)
      |=> (!arm_first_q && !arm_second_q));

  // R2/R3: a restart consumes both keys
  p_kick_disarms_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |=> (!arm_first_q && !arm_second_q));

  // R9: a timeout drops a half-entered pair
  p_expire_disarms_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> (!arm_first_q && !arm_second_q));
endmodule

// File: rtl/wdk_tmo_cnt.sv
module wdk_tmo_cnt #(
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic expire_o,
  output logic req_o
);
  localparam int unsigned CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             cnt_en;

  // next-state
  always_comb begin
    cnt_en   = 1'b1;
    expire_o = (cnt_q == LIMIT) && !kick_i;
    cnt_d    = cnt_q;
    if (kick_i || expire_o) cnt_d = '0;
    else if (cnt_en)        cnt_d = cnt_q + CNT_W'(1);
    req_d = expire_o;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

  // R5: the request is a single-cycle pulse
  p_req_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);

  // R2: a restart clears the count
  p_restart_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == '0));

  // R5: the count never passes the terminal value
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);

  // R5: a timeout restarts the count by itself
  p_self_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> (cnt_q == '0));
endmodule

// File: rtl/wdog_dualkey.sv
module wdog_dualkey
  import wdk_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TIMEOUT     = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              pin_rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              rst_req_o
);
  logic    rst_n;
  key_wr_t key_wr;
  logic    kick, expire;
  logic    cause_q, cause_d;

  wdk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i      (clk_i),
    .pin_rst_ni (pin_rst_ni),
    .rst_no     (rst_n)
  );

  wdk_bus_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus_dec (
    .bus_wr_i     (bus_wr_i),
    .bus_rd_i     (bus_rd_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .cause_flag_i (cause_q),
    .key_wr_o     (key_wr),
    .bus_rdata_o  (bus_rdata_o)
  );

  wdk_key_arm u_key_arm (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .key_wr_i (key_wr),
    .expire_i (expire),
    .kick_o   (kick)
  );

  wdk_tmo_cnt #(.TIMEOUT(TIMEOUT)) u_tmo_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .kick_i   (kick),
    .expire_o (expire),
    .req_o    (rst_req_o)
  );

  // cause flag: set by timeout, cleared only through the pin-driven reset
  always_comb cause_d = cause_q | expire;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cause_q <= 1'b0;
    else        cause_q <= cause_d;
  end

  // R7: the flag is sticky while the pin reset stays high
  p_cause_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    cause_q |=> cause_q);

  // R6: the flag is set no later than the request pulse
  p_req_sets_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_req_o |-> cause_q);
endmodule

// File: tb/wdog_dualkey_tb.sv
module wdog_dualkey_tb;
  localparam int unsigned T    = 40;
  localparam int unsigned AW   = 8;
  localparam int unsigned DW   = 32;

  logic          clk = 1'b0;
  logic          pin_rst_n;
  logic          wr, rd;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  wdog_dualkey #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT(T)) u_dut (
    .clk_i       (clk),
    .pin_rst_ni  (pin_rst_n),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .rst_req_o   (req)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // all tasks start just after a falling edge
  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                          input string rq);
    rd = 1'b1; addr = a;
    #1;
    chk(rdata === exp, rq, "read", rdata, exp);
    rd = 1'b0; addr = '0;
  endtask

  // elapsed = edges already passed since the restart edge
  task automatic expect_timeout(input int elapsed, input string rq);
    for (int i = elapsed + 1; i < int'(T); i++) begin
      @(negedge clk);
      chk(req === 1'b0, rq, "request early", 32'(req), 32'd0);
    end
    @(negedge clk);
    chk(req === 1'b1, rq, "request due", 32'(req), 32'd1);
    @(negedge clk);
    chk(req === 1'b0, "R5", "request width", 32'(req), 32'd0);
  endtask

  task automatic pin_reset();
    pin_rst_n = 1'b0;
    #1;
    chk(req === 1'b0, "R1", "request in reset", 32'(req), 32'd0);
    read_chk(8'h18, 32'd0, "R1");
    repeat (3) @(negedge clk);
    pin_rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_first_then_second();
    read_chk(8'h18, 32'd0, "R1");
    bus_wr(8'h10, 32'hA);
    bus_wr(8'h14, 32'h5);
    expect_timeout(0, "R2");
  endtask

  task automatic t_second_then_first();
    bus_wr(8'h14, 32'h5);
    bus_wr(8'h10, 32'hA);
    expect_timeout(0, "R3");
  endtask

  task automatic t_wrong_keys();
    bus_wr(8'h10, 32'hA);
    bus_wr(8'h14, 32'h5);      // restart
    bus_wr(8'h10, 32'hA);
    bus_wr(8'h14, 32'h3);      // wrong
    bus_wr(8'h14, 32'h5);      // alone, no restart
    expect_timeout(3, "R4");
    bus_wr(8'h14, 32'h5);
    bus_wr(8'h10, 32'hA);      // restart
    bus_wr(8'h14, 32'h5);
    bus_wr(8'h10, 32'h1A);     // wrong: upper bits set
    bus_wr(8'h10, 32'hA);      // alone, no restart
    expect_timeout(3, "R4");
  endtask

  task automatic t_cause_flag();
    read_chk(8'h18, 32'd1, "R6");
    bus_wr(8'h18, 32'h0);
    read_chk(8'h18, 32'd1, "R6");
    read_chk(8'h10, 32'd0, "R8");
    read_chk(8'h14, 32'd0, "R8");
    bus_wr(8'h10, 32'hA);
    bus_wr(8'h14, 32'h5);
    read_chk(8'h18, 32'd1, "R7");
    expect_timeout(0, "R7");
    read_chk(8'h18, 32'd1, "R7");
  endtask

  task automatic t_timeout_drops_half();
    bus_wr(8'h10, 32'hA);
    bus_wr(8'h14, 32'h5);      // restart at edge E
    bus_wr(8'h10, 32'hA);      // half pair at E+1
    expect_timeout(1, "R9");
    bus_wr(8'h14, 32'h5);      // second key after timeout
    expect_timeout(2, "R9");
  endtask

  task automatic t_pin_clears();
    @(negedge clk);
    #2;
    pin_reset();
    read_chk(8'h18, 32'd0, "R7");
    bus_wr(8'h14, 32'h5);
    bus_wr(8'h10, 32'hA);
    read_chk(8'h18, 32'd0, "R7");
    expect_timeout(0, "R3");
    read_chk(8'h18, 32'd1, "R6");
  endtask

  initial begin
    pin_rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    @(negedge clk);
    pin_reset();
    t_first_then_second();
    t_cause_flag();
    t_second_then_first();
    t_wrong_keys();
    t_timeout_drops_half();
    t_pin_clears();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule